// File: doc/BRIEF.md
# Power-Good Gated Platform Error Router

This block sits between two processors and a platform health monitor. It forwards each processor's error and thermal status, the system management interrupt lines and the non-maskable interrupt line. Two active-high power-good inputs, `pg_a` for processor 0 and `pg_b` for processor 1 and the shared interrupt paths, gate every route. While a processor is unpowered, or the board is still coming up, no false fault reaches the monitor or the processors.

Board-level open-drain pins appear as pull-low enables: a 1 on a `*_pull` output means the line is driven low, and a 0 means it is released. The buffered interrupt copy is modelled as a value plus an output enable. Each shared thermal line is split into a sensed input (`hot_line_n`) and a pull-low output (`hot_pull`). Every output is registered, so it reflects the inputs sampled at the previous rising clock edge.

Each processor's thermal path has a small state machine with three states:
- ARMED: throttle reporting is allowed.
- SELF: the processor itself reports hot.
- BLANK: cycles are counted after the processor's hot signal is released.

The transitions are:
- ARMED→SELF when `hot_n` goes low.
- SELF→BLANK when `hot_n` returns high. This is the rising edge, and it loads the counter.
- BLANK→SELF when `hot_n` goes low again.
- BLANK→ARMED when the count expires with `hot_n` high.

The throttle output can assert only in ARMED. This blanks the window in which the shared line is still slowly recovering from the processor's own assertion.

Top module: `pg_err_router`

## Requirements
- R1: Each bit of `err_pull_a` is 1 one cycle after `pg_a`=1 with the matching `err_a_n` bit at 0. It is 0 whenever `pg_a` was 0 (released, high-Z).
- R2: `err_pull_b` behaves the same way from `err_b_n`, gated by `pg_b`.
- R3: `hot_pull[0]` is 1 one cycle after `pg_a`=1 and `hot_n[0]`=0, and `hot_pull[1]` likewise with `pg_b` and `hot_n[1]`. With the enable at 0 the coupling is open (0).
- R4: `nmi_out` is forced to 0 whenever `pg_b` was 0, including right after reset. Otherwise it follows `nmi_src` one cycle later.
- R5: `smi_buf_oe` equals `pg_b` one cycle later, and `smi_buf_val` follows `sys_smi_n` one cycle later.
- R6: `smi_pull[i]` is 1 only when, in the previous cycle, `pg_b`=1, `smi_req_n[i]`=0 and `sys_smi_n`=0.
- R7: `throt_pull[i]` is 1 only when the shared line `hot_line_n[i]` is 0 while the processor's own `hot_n[i]` is 1, its enable is 1 and the machine is ARMED. A processor asserting hot itself never throttles.
- R8: Each rising edge of `hot_n[i]` blocks `throt_pull[i]` for BLANK_CYC cycles (default 10, 200 ns at 50 MHz). A line held low from that edge shows `throt_pull` first at the sample after BLANK_CYC+2 rising edges, and a shorter lag produces no pulse at all.
- R9: A synchronous active-low `rst_n` clears all pull and enable outputs and forces `nmi_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pg_a | input | 1 | Power-good enable, processor 0 |
| pg_b | input | 1 | Power-good enable, processor 1 and interrupts |
| err_a_n | input | 2 | Processor 0 error inputs, active low |
| err_b_n | input | 2 | Processor 1 error inputs, active low |
| hot_n | input | 2 | Per-processor thermal-hot inputs, active low |
| hot_line_n | input | 2 | Sensed level of each shared thermal line |
| smi_req_n | input | 2 | Per-processor SMI request inputs, active low |
| sys_smi_n | input | 1 | System SMI level, active low |
| nmi_src | input | 1 | NMI level from the chipset |
| err_pull_a | output | 2 | Pull-low enables, processor 0 error lines |
| err_pull_b | output | 2 | Pull-low enables, processor 1 error lines |
| hot_pull | output | 2 | Pull-low enables onto the shared thermal lines |
| throt_pull | output | 2 | Pull-low enables, per-processor throttle outputs |
| smi_pull | output | 2 | Pull-low enables, per-processor SMI outputs |
| smi_buf_val | output | 1 | Buffered SMI value |
| smi_buf_oe | output | 1 | Buffered SMI output enable |
| nmi_out | output | 1 | NMI to processors, forced low while disabled |

## Verification
The assertions assume that every input is already synchronous to `clk` and changes only between rising edges. The bench meets this by driving all inputs on the falling edge. The assertions also assume that `hot_line_n` is an independent sensed value, so the throttle properties relate only the processor's own hot input, the enable and the previous state. The bench therefore drives the shared line on its own, which lets it model both a slowly recovering line and a line pulled low by another agent. It sets the reset state with the enables high and errors asserted, so that the reset clearing is visible on every output.

// File: rtl/pg_err_pkg.sv
package pg_err_pkg;
    // per-processor thermal blanking machine
    typedef enum logic [1:0] {
        TB_ARMED = 2'd0,
        TB_SELF  = 2'd1,
        TB_BLANK = 2'd2
    } tb_state_e;

    localparam int unsigned NUM_CPU = 2;
endpackage

// File: rtl/therm_blank.sv
module therm_blank
    import pg_err_pkg::*;
#(
    parameter int unsigned BLANK_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pg,
    input  logic hot_n,
    input  logic line_n,
    output logic throt_pull
);
    localparam int unsigned CW = $clog2(BLANK_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(BLANK_CYC - 1);

    tb_state_e       state_q, state_d;
    logic [CW-1:0]   cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TB_ARMED: if (!hot_n) state_d = TB_SELF;
            TB_SELF:  if (hot_n)  state_d = TB_BLANK;
            TB_BLANK: begin
                if (!hot_n)               state_d = TB_SELF;
                else if (cnt_q == '0)     state_d = TB_ARMED;
            end
            default:                      state_d = TB_ARMED;
        endcase
    end

    // state register and blanking counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TB_ARMED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == TB_SELF && state_d == TB_BLANK)
                cnt_q <= LOAD;
            else if (state_q == TB_BLANK && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n)
            throt_pull <= 1'b0;
        else
            throt_pull <= pg && (state_q == TB_ARMED) && hot_n && !line_n;
    end
endmodule

// File: rtl/pg_gate.sv
module pg_gate #(
    parameter int unsigned ERR_W = 2
) (
    input  logic             pg_a,
    input  logic             pg_b,
    input  logic [ERR_W-1:0] err_a_n,
    input  logic [ERR_W-1:0] err_b_n,
    input  logic [1:0]       hot_n,
    input  logic [1:0]       smi_req_n,
    input  logic             sys_smi_n,
    input  logic             nmi_src,
    output logic [ERR_W-1:0] err_pull_a_d,
    output logic [ERR_W-1:0] err_pull_b_d,
    output logic [1:0]       hot_pull_d,
    output logic [1:0]       smi_pull_d,
    output logic             smi_oe_d,
    output logic             smi_val_d,
    output logic             nmi_d
);
    logic [1:0] pg_vec;
    assign pg_vec = {pg_b, pg_a};

    always_comb begin
        err_pull_a_d = {ERR_W{pg_a}} & ~err_a_n;
        err_pull_b_d = {ERR_W{pg_b}} & ~err_b_n;
        hot_pull_d   = pg_vec & ~hot_n;
        smi_pull_d   = {2{pg_b & ~sys_smi_n}} & ~smi_req_n;
        smi_oe_d     = pg_b;
        smi_val_d    = sys_smi_n;
        nmi_d        = pg_b ? nmi_src : 1'b0;
    end
endmodule

// File: rtl/pg_err_router.sv
module pg_err_router
    import pg_err_pkg::*;
#(
    parameter int unsigned ERR_W     = 2,
    parameter int unsigned BLANK_CYC = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pg_a,
    input  logic             pg_b,
    input  logic [ERR_W-1:0] err_a_n,
    input  logic [ERR_W-1:0] err_b_n,
    input  logic [1:0]       hot_n,
    input  logic [1:0]       hot_line_n,
    input  logic [1:0]       smi_req_n,
    input  logic             sys_smi_n,
    input  logic             nmi_src,
    output logic [ERR_W-1:0] err_pull_a,
    output logic [ERR_W-1:0] err_pull_b,
    output logic [1:0]       hot_pull,
    output logic [1:0]       throt_pull,
    output logic [1:0]       smi_pull,
    output logic             smi_buf_val,
    output logic             smi_buf_oe,
    output logic             nmi_out
);
    logic [ERR_W-1:0] err_pull_a_d, err_pull_b_d;
    logic [1:0]       hot_pull_d, smi_pull_d;
    logic             smi_oe_d, smi_val_d, nmi_d;
    logic [1:0]       pg_vec;

    assign pg_vec = {pg_b, pg_a};

    pg_gate #(.ERR_W(ERR_W)) u_gate (
        .pg_a         (pg_a),
        .pg_b         (pg_b),
        .err_a_n      (err_a_n),
        .err_b_n      (err_b_n),
        .hot_n        (hot_n),
        .smi_req_n    (smi_req_n),
        .sys_smi_n    (sys_smi_n),
        .nmi_src      (nmi_src),
        .err_pull_a_d (err_pull_a_d),
        .err_pull_b_d (err_pull_b_d),
        .hot_pull_d   (hot_pull_d),
        .smi_pull_d   (smi_pull_d),
        .smi_oe_d     (smi_oe_d),
        .smi_val_d    (smi_val_d),
        .nmi_d        (nmi_d)
    );

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
        therm_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
            .clk        (clk),
            .rst_n      (rst_n),
            .pg         (pg_vec[i]),
            .hot_n      (hot_n[i]),
            .line_n     (hot_line_n[i]),
            .throt_pull (throt_pull[i])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_pull_a  <= '0;
            err_pull_b  <= '0;
            hot_pull    <= '0;
            smi_pull    <= '0;
            smi_buf_oe  <= 1'b0;
            smi_buf_val <= 1'b0;
            nmi_out     <= 1'b0;
        end else begin
            err_pull_a  <= err_pull_a_d;
            err_pull_b  <= err_pull_b_d;
            hot_pull    <= hot_pull_d;
            smi_pull    <= smi_pull_d;
            smi_buf_oe  <= smi_oe_d;
            smi_buf_val <= smi_val_d;
            nmi_out     <= nmi_d;
        end
    end
endmodule

// File: rtl/pg_err_router_chk.sv
module pg_err_router_chk #(
    parameter int unsigned ERR_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pg_a,
    input logic             pg_b,
    input logic [1:0]       hot_n,
    input logic [ERR_W-1:0] err_pull_a,
    input logic [ERR_W-1:0] err_pull_b,
    input logic [1:0]       hot_pull,
    input logic [1:0]       throt_pull,
    input logic [1:0]       smi_pull,
    input logic             smi_buf_oe,
    input logic             nmi_out
);
    logic [1:0] pg_vec;
    assign pg_vec = {pg_b, pg_a};

    // R1
    err_a_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_a |=> (err_pull_a == '0));
    // R2
    err_b_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_b |=> (err_pull_b == '0));
    // R4
    nmi_forced_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_b |=> !nmi_out);
    // R5
    smi_buf_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_b |=> !smi_buf_oe);
    // R6
    smi_pull_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_b |=> (smi_pull == 2'b00));

    for (genvar i = 0; i < 2; i++) begin : g_chk
        // R3
        hot_couple_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pg_vec[i] && !hot_n[i]) |=> hot_pull[i]);
        // R7
        throt_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !hot_n[i] |=> !throt_pull[i]);
        // R8
        throt_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(hot_n[i]) |=> !throt_pull[i]);
    end
endmodule

bind pg_err_router pg_err_router_chk #(.ERR_W(ERR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pg_a       (pg_a),
    .pg_b       (pg_b),
    .hot_n      (hot_n),
    .err_pull_a (err_pull_a),
    .err_pull_b (err_pull_b),
    .hot_pull   (hot_pull),
    .throt_pull (throt_pull),
    .smi_pull   (smi_pull),
    .smi_buf_oe (smi_buf_oe),
    .nmi_out    (nmi_out)
);

// File: tb/test_pg_err_router.sv
module test_pg_err_router;
    logic       clk = 1'b0;
    logic       rst_n, pg_a, pg_b, sys_smi_n, nmi_src;
    logic [1:0] err_a_n, err_b_n, hot_n, hot_line_n, smi_req_n;
    logic [1:0] err_pull_a, err_pull_b, hot_pull, throt_pull, smi_pull;
    logic       smi_buf_val, smi_buf_oe, nmi_out;
    int         n_chk = 0;
    int         n_bad = 0;

    always #10 clk = ~clk;

    pg_err_router i_pg_err_router (
        .clk(clk), .rst_n(rst_n), .pg_a(pg_a), .pg_b(pg_b),
        .err_a_n(err_a_n), .err_b_n(err_b_n), .hot_n(hot_n),
        .hot_line_n(hot_line_n), .smi_req_n(smi_req_n),
        .sys_smi_n(sys_smi_n), .nmi_src(nmi_src),
        .err_pull_a(err_pull_a), .err_pull_b(err_pull_b),
        .hot_pull(hot_pull), .throt_pull(throt_pull), .smi_pull(smi_pull),
        .smi_buf_val(smi_buf_val), .smi_buf_oe(smi_buf_oe), .nmi_out(nmi_out)
    );

    // stimulus {pg_a, pg_b, err_a_n, err_b_n, smi_req_n, sys_smi_n, nmi_src}
    localparam logic [9:0] STIM [8] = '{
        10'b0000000001, 10'b1000000001, 10'b0110010001, 10'b1101100100,
        10'b1111110011, 10'b1100001001, 10'b0100110010, 10'b1010000001
    };
    // expected {err_pull_a, err_pull_b, smi_pull, smi_buf_oe, smi_buf_val, nmi_out}
    localparam logic [8:0] EXPV [8] = '{
        9'b000000000, 9'b110000000, 9'b001011101, 9'b100110100,
        9'b000000111, 9'b111101101, 9'b000000110, 9'b010000000
    };

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [8:0] table_out();
        return {err_pull_a, err_pull_b, smi_pull, smi_buf_oe, smi_buf_val, nmi_out};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic seen;
        rst_n = 1'b0; pg_a = 1'b1; pg_b = 1'b1;
        err_a_n = 2'b00; err_b_n = 2'b00; hot_n = 2'b00; hot_line_n = 2'b00;
        smi_req_n = 2'b00; sys_smi_n = 1'b0; nmi_src = 1'b1;
        tick(3);
        // R9: reset clears everything even with enables and faults active
        check("R9 reset", {7'b0, table_out()}, 16'h0);
        check("R9 reset hot/throt", {12'b0, hot_pull, throt_pull}, 16'h0);

        // power-up: enables held low, faults still present
        pg_a = 1'b0; pg_b = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        tick(5);
        check("R1 R2 R6 power-up released", {7'b0, table_out()}, 16'h0);
        check("R4 nmi low at power-up", {15'b0, nmi_out}, 16'h0);
        check("R5 buffer high-Z at power-up", {15'b0, smi_buf_oe}, 16'h0);
        check("R3 R7 power-up hot/throt", {12'b0, hot_pull, throt_pull}, 16'h0);

        hot_n = 2'b11; hot_line_n = 2'b11;
        for (int v = 0; v < 8; v++) begin
            {pg_a, pg_b, err_a_n, err_b_n, smi_req_n, sys_smi_n, nmi_src} = STIM[v];
            tick(1);
            // R1 R2 R4 R5 R6 table vector
            check($sformatf("R1/R2/R4/R5/R6 vector %0d", v), {7'b0, table_out()}, {7'b0, EXPV[v]});
        end

        // enable toggling during an active fault
        pg_a = 1'b1; pg_b = 1'b0; err_a_n = 2'b10; err_b_n = 2'b01;
        sys_smi_n = 1'b1; smi_req_n = 2'b11; tick(1);
        check("R1 fault with enable", {14'b0, err_pull_a}, 16'h1);
        pg_a = 1'b0; tick(1);
        check("R1 enable dropped", {14'b0, err_pull_a}, 16'h0);
        pg_a = 1'b1; pg_b = 1'b1; tick(1);
        check("R1 enable restored", {14'b0, err_pull_a}, 16'h1);
        check("R2 fault with enable", {14'b0, err_pull_b}, 16'h2);
        pg_b = 1'b0; tick(1);
        check("R2 enable dropped", {14'b0, err_pull_b}, 16'h0);
        pg_b = 1'b1; err_a_n = 2'b11; err_b_n = 2'b11;

        // processor 0 reports hot itself
        hot_n = 2'b10; hot_line_n = 2'b10; tick(1);
        check("R3 hot coupled", {14'b0, hot_pull}, 16'h1);
        check("R7 self hot no throttle", {14'b0, throt_pull}, 16'h0);
        pg_a = 1'b0; tick(1);
        check("R3 coupling open", {14'b0, hot_pull}, 16'h0);
        pg_a = 1'b1; tick(2);

        // short lag after release
        hot_n = 2'b11; seen = 1'b0;
        for (int i = 0; i < 16; i++) begin
            if (i == 3) hot_line_n = 2'b11;
            tick(1);
            seen = seen | throt_pull[0];
        end
        check("R8 short lag no glitch", {15'b0, seen}, 16'h0);

        // long lag: line stuck low past the blanking window
        hot_n = 2'b10; hot_line_n = 2'b10; tick(2);
        hot_n = 2'b11; tick(11);
        check("R8 still blanked at boundary", {14'b0, throt_pull}, 16'h0);
        tick(1);
        check("R8 throttle after blanking", {14'b0, throt_pull}, 16'h1);
        hot_line_n = 2'b11; tick(1);
        check("R7 throttle released", {14'b0, throt_pull}, 16'h0);

        // external agent pulls the line while processors are cool
        hot_line_n = 2'b10; tick(1);
        check("R7 external pull cpu0", {14'b0, throt_pull}, 16'h1);
        pg_a = 1'b0; tick(1);
        check("R7 throttle gated by enable", {14'b0, throt_pull}, 16'h0);
        pg_a = 1'b1; hot_line_n = 2'b01; tick(1);
        check("R7 external pull cpu1", {14'b0, throt_pull}, 16'h2);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule